// File: doc/BRIEF.md
# Interrupt routing controller

This block collects interrupt requests from on-chip peripherals and external lines and presents them to a processor on three request outputs ranked by urgency. From most to least urgent they are critical, system-management and standard. A fourth output, machine check, exists only so the processor pin has a driver. It is held low at all times, because bus errors do not pass through this block.

Each source has a sticky pending bit that is set on the source's rising edge. Four sources are wired to the critical output: the DMA engine's urgent request, external line 0, timer 0 and the clock-control wake event. Timer 1 is wired to the system-management output. Each remaining source is steered by a routing bit to either the system-management output or the standard output. Out of reset every routing bit selects the standard output, which is where slow functions such as GPIO and the real-time clock belong.

A per-source mask bit keeps a pending request away from its output. A request output stays asserted for as long as any unmasked pending bit routed to it remains, so the handler must clear every source before the line falls. Per-output status registers tell the handler which sources are asking. A small register bus with combinational reads gives access to routing, mask, raw pending and status.

Each output line is a two-state machine. `LINE_QUIET` moves to `LINE_HELD` when any unmasked pending bit is routed to that line (transition *raise*). `LINE_HELD` returns to `LINE_QUIET` once none are left (transition *release*). Each state otherwise holds (transitions *wait* and *hold*).

Top module: `irq_router`

## Requirements
- R1: `cpu_mcheck_o` is 0 in every cycle, including during reset.
- R2: Pending bits 0 to 3 (DMA urgent, external line 0, timer 0, wake event, taken from `crit_src_i[3:0]`) feed only `cpu_crit_o`. The routing register does not affect them.
- R3: Pending bit 4 (`tmr1_src_i`) feeds only `cpu_smi_o`, whatever the routing register holds.
- R4: Pending bit 5+i (`prog_src_i[i]`) feeds `cpu_smi_o` when routing bit i is 1 and `cpu_std_o` when it is 0. The routing register is at address 0 and bits 0 to NPROG-1 are read/write.
- R5: A pending bit is set by a 0-to-1 change of its source and then stays set. A source that remains high does not set it again after it is cleared. An output rises on the second rising clock edge after its source rises.
- R6: Writing address 2 clears every pending bit whose write-data bit is 1 and leaves the bits written with 0 unchanged. If a clear and a new rising edge of the same source fall in the same cycle, the bit ends up set.
- R7: An output stays 1 while at least one unmasked pending bit is routed to it. It returns to 0 one clock edge after the last such bit is cleared, masked or rerouted.
- R8: Mask register at address 1: bit n = 1 keeps pending bit n away from its output. Address 2 reads back the raw pending bits, masked ones included.
- R9: Status registers at addresses 3 (critical), 4 (system-management) and 5 (standard) read the unmasked pending bits routed to that output, each at its pending-bit position.
- R10: Reads of addresses 6 and 7 return 0. Writes to addresses 3 to 7 change no state. Read-data bits above the register width read 0.
- R11: While `rst_n` is low, all pending, mask and routing bits are 0 and all request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| crit_src_i | input | 4 | Fixed critical sources: DMA urgent, external line 0, timer 0, wake |
| tmr1_src_i | input | 1 | Timer 1 request, fixed to system-management |
| prog_src_i | input | NPROG | Routable sources |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data for `bus_addr_i`, combinational |
| cpu_crit_o | output | 1 | Critical request |
| cpu_smi_o | output | 1 | System-management request |
| cpu_std_o | output | 1 | Standard request |
| cpu_mcheck_o | output | 1 | Machine check, always 0 |

## Verification
Two events can land in the same cycle: a software clear of a pending bit and a new rising edge of that bit's source. The bench provokes this on purpose by raising a source in the very cycle that a write to address 2 clears it. A line that is already held is then expected to stay asserted with its pending bit set. In the same way, a routing write can coincide with a pending request, and the request is then expected to move from one output to the other within a single edge. The behavioural reference model predicts the outputs and every read address on each cycle, covering these directed collisions and a long stretch of random traffic.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    // Bit layout of the unified pending vector (behaviour-relevant).
    localparam int CRIT_SRCS = 4;
    localparam int TMR1_POS  = CRIT_SRCS;
    localparam int PROG_BASE = CRIT_SRCS + 1;
    localparam int AW        = 3;

    typedef enum logic [AW-1:0] {
        REG_ROUTE = 3'd0,
        REG_MASK  = 3'd1,
        REG_PEND  = 3'd2,
        REG_CRIT  = 3'd3,
        REG_SMI   = 3'd4,
        REG_STD   = 3'd5
    } reg_addr_e;

    typedef enum logic {
        LINE_QUIET = 1'b0,
        LINE_HELD  = 1'b1
    } line_state_e;

    // Index of each request line in the line vectors.
    localparam int LINE_CRIT = 0;
    localparam int LINE_SMI  = 1;
    localparam int LINE_STD  = 2;
    localparam int NLINES    = 3;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
    parameter int NSRC = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] pend_o
);
    logic [NSRC-1:0] prev_q;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] pend_d;

    // A fresh edge outranks a clear in the same cycle.
    always_comb begin
        rise   = src_i & ~prev_q;
        pend_d = (pend_q & ~clr_i) | rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= src_i;
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_router_pkg::*;
#(
    parameter int NPROG = 8,
    parameter int NSRC  = PROG_BASE + NPROG,
    parameter int DW    = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic [NSRC-1:0] pend_i,
    output logic [DW-1:0]   rdata_o,
    output logic [NSRC-1:0] clr_o,
    output logic [NSRC-1:0] crit_st_o,
    output logic [NSRC-1:0] smi_st_o,
    output logic [NSRC-1:0] std_st_o
);
    logic [NPROG-1:0] route_q;
    logic [NSRC-1:0]  mask_q;
    logic [NSRC-1:0]  wbits;
    logic [NSRC-1:0]  live;
    logic [NSRC-1:0]  crit_sel;
    logic [NSRC-1:0]  smi_sel;
    logic [NSRC-1:0]  std_sel;

    assign wbits = wdata_i[NSRC-1:0];

    generate
        if (DW > NSRC) begin : g_hi
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^wdata_i[DW-1:NSRC];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= '0;
            mask_q  <= '0;
        end else if (wr_i) begin
            if (addr_i == REG_ROUTE) route_q <= wbits[NPROG-1:0];
            if (addr_i == REG_MASK)  mask_q  <= wbits;
        end
    end

    assign clr_o = (wr_i && addr_i == REG_PEND) ? wbits : '0;

    // Per-bit steering: fixed for the first sources, programmable above.
    generate
        for (genvar b = 0; b < NSRC; b++) begin : g_sel
            if (b < CRIT_SRCS) begin : g_crit
                assign crit_sel[b] = 1'b1;
                assign smi_sel[b]  = 1'b0;
                assign std_sel[b]  = 1'b0;
            end else if (b == TMR1_POS) begin : g_tmr1
                assign crit_sel[b] = 1'b0;
                assign smi_sel[b]  = 1'b1;
                assign std_sel[b]  = 1'b0;
            end else begin : g_prog
                assign crit_sel[b] = 1'b0;
                assign smi_sel[b]  = route_q[b-PROG_BASE];
                assign std_sel[b]  = ~route_q[b-PROG_BASE];
            end
        end
    endgenerate

    always_comb begin
        live      = pend_i & ~mask_q;
        crit_st_o = live & crit_sel;
        smi_st_o  = live & smi_sel;
        std_st_o  = live & std_sel;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            REG_ROUTE: rdata_o[NPROG-1:0] = route_q;
            REG_MASK:  rdata_o[NSRC-1:0]  = mask_q;
            REG_PEND:  rdata_o[NSRC-1:0]  = pend_i;
            REG_CRIT:  rdata_o[NSRC-1:0]  = crit_st_o;
            REG_SMI:   rdata_o[NSRC-1:0]  = smi_st_o;
            REG_STD:   rdata_o[NSRC-1:0]  = std_st_o;
            default:   rdata_o            = '0;
        endcase
    end
endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import irq_router_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic irq_o
);
    line_state_e state_q;
    line_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET: if (req_i)  state_d = LINE_HELD;   // raise
            LINE_HELD:  if (!req_i) state_d = LINE_QUIET;  // release
            default:                state_d = LINE_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LINE_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == LINE_HELD);
    end
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NPROG = 8,
    parameter int DW    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CRIT_SRCS-1:0] crit_src_i,
    input  logic                 tmr1_src_i,
    input  logic [NPROG-1:0]     prog_src_i,
    input  logic                 bus_wr_i,
    input  logic [AW-1:0]        bus_addr_i,
    input  logic [DW-1:0]        bus_wdata_i,
    output logic [DW-1:0]        bus_rdata_o,
    output logic                 cpu_crit_o,
    output logic                 cpu_smi_o,
    output logic                 cpu_std_o,
    output logic                 cpu_mcheck_o
);
    localparam int NSRC = PROG_BASE + NPROG;

    logic [NSRC-1:0]   src_all;
    logic [NSRC-1:0]   clr;
    logic [NSRC-1:0]   pend_q;
    logic [NSRC-1:0]   crit_st;
    logic [NSRC-1:0]   smi_st;
    logic [NSRC-1:0]   std_st;
    logic [NLINES-1:0] line_req;
    logic [NLINES-1:0] line_irq;

    assign src_all = {prog_src_i, tmr1_src_i, crit_src_i};

    irq_capture #(.NSRC(NSRC)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_all),
        .clr_i  (clr),
        .pend_o (pend_q)
    );

    irq_regs #(.NPROG(NPROG), .NSRC(NSRC), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (bus_wr_i),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .pend_i    (pend_q),
        .rdata_o   (bus_rdata_o),
        .clr_o     (clr),
        .crit_st_o (crit_st),
        .smi_st_o  (smi_st),
        .std_st_o  (std_st)
    );

    assign line_req[LINE_CRIT] = |crit_st;
    assign line_req[LINE_SMI]  = |smi_st;
    assign line_req[LINE_STD]  = |std_st;

    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_line
            irq_line_fsm u_line (
                .clk   (clk),
                .rst_n (rst_n),
                .req_i (line_req[g]),
                .irq_o (line_irq[g])
            );
        end
    endgenerate

    assign cpu_crit_o   = line_irq[LINE_CRIT];
    assign cpu_smi_o    = line_irq[LINE_SMI];
    assign cpu_std_o    = line_irq[LINE_STD];
    assign cpu_mcheck_o = 1'b0;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int NSRC = 13
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr_i,
    input logic [AW-1:0]   bus_addr_i,
    input logic [NSRC-1:0] pend,
    input logic [NSRC-1:0] crit_st,
    input logic [NSRC-1:0] smi_st,
    input logic [NSRC-1:0] std_st,
    input logic            cpu_crit_o,
    input logic            cpu_smi_o,
    input logic            cpu_mcheck_o
);
    a_r1_mcheck_idle: assert property (@(posedge clk) cpu_mcheck_o == 1'b0);

    a_r7_crit_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (|crit_st) |=> cpu_crit_o);

    a_r7_crit_release: assert property (@(posedge clk) disable iff (!rst_n)
        !(|crit_st) |=> !cpu_crit_o);

    a_r3_tmr1_to_smi: assert property (@(posedge clk) disable iff (!rst_n)
        smi_st[TMR1_POS] |=> cpu_smi_o);

    a_r4_routes_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_st & std_st) == '0);

    a_r5_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_i && bus_addr_i == REG_PEND) |=> ((pend & $past(pend)) == $past(pend)));
endmodule

bind irq_router irq_router_chk #(.NSRC(NSRC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr_i     (bus_wr_i),
    .bus_addr_i   (bus_addr_i),
    .pend         (pend_q),
    .crit_st      (crit_st),
    .smi_st       (smi_st),
    .std_st       (std_st),
    .cpu_crit_o   (cpu_crit_o),
    .cpu_smi_o    (cpu_smi_o),
    .cpu_mcheck_o (cpu_mcheck_o)
);

// File: tb/irq_router_tb.sv
module irq_router_tb;
    localparam int NPROG = 8;
    localparam int NSRC  = 5 + NPROG;
    localparam int DW    = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       crit_src = '0;
    logic             tmr1_src = 1'b0;
    logic [NPROG-1:0] prog_src = '0;
    logic             wr = 1'b0;
    logic [2:0]       addr = '0;
    logic [DW-1:0]    wdata = '0;
    logic [DW-1:0]    rdata;
    logic             o_crit, o_smi, o_std, o_mck;

    always #2 clk = ~clk;

    irq_router #(.NPROG(NPROG), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .crit_src_i(crit_src), .tmr1_src_i(tmr1_src),
        .prog_src_i(prog_src), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .cpu_crit_o(o_crit), .cpu_smi_o(o_smi),
        .cpu_std_o(o_std), .cpu_mcheck_o(o_mck)
    );

    int vectors = 0;
    int misses  = 0;
    bit started = 0;
    bit done    = 0;

    // Behavioural reference state.
    logic [NSRC-1:0]  m_pend = '0, m_mask = '0, m_prev = '0;
    logic [NPROG-1:0] m_route = '0;
    logic             m_crit = 0, m_smi = 0, m_std = 0;

    function automatic int dest_of(int n);   // 0 crit, 1 smi, 2 std
        if (n < 4) return 0;
        if (n == 4) return 1;
        return m_route[n-5] ? 1 : 2;
    endfunction

    always @(posedge clk) begin
        logic [NSRC-1:0] srcs;
        logic [NSRC-1:0] clrs;
        logic c, s, t;
        started = 1;
        if (!rst_n) begin
            m_pend = '0; m_mask = '0; m_prev = '0; m_route = '0;
            m_crit = 0; m_smi = 0; m_std = 0;
        end else begin
            c = 0; s = 0; t = 0;
            for (int n = 0; n < NSRC; n++)
                if (m_pend[n] && !m_mask[n]) begin
                    if (dest_of(n) == 0) c = 1;
                    else if (dest_of(n) == 1) s = 1;
                    else t = 1;
                end
            m_crit = c; m_smi = s; m_std = t;
            srcs = {prog_src, tmr1_src, crit_src};
            clrs = (wr && addr == 3'd2) ? wdata[NSRC-1:0] : '0;
            for (int n = 0; n < NSRC; n++) begin
                if (clrs[n]) m_pend[n] = 0;
                if (srcs[n] && !m_prev[n]) m_pend[n] = 1;
            end
            m_prev = srcs;
            if (wr && addr == 3'd0) m_route = wdata[NPROG-1:0];
            if (wr && addr == 3'd1) m_mask  = wdata[NSRC-1:0];
        end
    end

    function automatic logic [DW-1:0] exp_rd(logic [2:0] a);
        logic [DW-1:0] v = '0;
        case (a)
            3'd0: v[NPROG-1:0] = m_route;
            3'd1: v[NSRC-1:0]  = m_mask;
            3'd2: v[NSRC-1:0]  = m_pend;
            3'd3, 3'd4, 3'd5:
                for (int n = 0; n < NSRC; n++)
                    if (m_pend[n] && !m_mask[n] && dest_of(n) == int'(a) - 3) v[n] = 1;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic string rd_tag(logic [2:0] a);
        case (a)
            3'd0: return "R4 route";
            3'd1: return "R8 mask";
            3'd2: return "R5 pend";
            3'd3, 3'd4, 3'd5: return "R9 status";
            default: return "R10 unused";
        endcase
    endfunction

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s t=%0t act=%h exp=%h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            chk("R1 mcheck", {31'b0, o_mck}, 32'd0);
            chk(rst_n ? "R2 crit" : "R11 reset crit", {31'b0, o_crit}, {31'b0, m_crit});
            chk(rst_n ? "R3 smi"  : "R11 reset smi",  {31'b0, o_smi},  {31'b0, m_smi});
            chk(rst_n ? "R4 std"  : "R11 reset std",  {31'b0, o_std},  {31'b0, m_std});
            chk(rst_n ? rd_tag(addr) : "R11 reset read", rdata, exp_rd(addr));
        end
    end

    int rot = 0;
    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            wr = 0; addr = 3'(rot); rot++;
        end
    endtask

    task automatic wreg(logic [2:0] a, logic [DW-1:0] d);
        @(posedge clk); #1;
        wr = 1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr = 0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            misses++;
            $display("FAIL R11 watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R11: reset state on every address
        idle(9);
        @(posedge clk); #1; rst_n = 1;
        idle(4);
        // R2 R5: each critical source pulses, output rises two edges later
        for (int b = 0; b < 4; b++) begin
            @(posedge clk); #1; crit_src[b] = 1;
            idle(3);
            @(posedge clk); #1; crit_src[b] = 0;
            wreg(3'd2, 32'(1 << b));
            idle(3);
        end
        // R5: held source is not re-captured after a clear
        @(posedge clk); #1; prog_src[0] = 1;
        idle(3);
        wreg(3'd2, 32'h1fff);
        idle(4);
        @(posedge clk); #1; prog_src[0] = 0;
        // R3: timer 1 goes to system-management under any routing
        wreg(3'd0, 32'hff);
        @(posedge clk); #1; tmr1_src = 1;
        idle(3);
        wreg(3'd0, 32'h00);
        idle(3);
        @(posedge clk); #1; tmr1_src = 0;
        wreg(3'd2, 32'h10);
        idle(3);
        // R4: split routing, then reroute while pending
        wreg(3'd0, 32'h55);
        @(posedge clk); #1; prog_src = '1;
        idle(8);
        wreg(3'd0, 32'hff);
        idle(3);
        wreg(3'd0, 32'h00);
        idle(3);
        // R7: clear one at a time, line holds until the last
        @(posedge clk); #1; prog_src = '0;
        for (int b = 0; b < NPROG; b++) begin
            wreg(3'd2, 32'(1 << (b + 5)));
            idle(2);
        end
        // R6: zero write has no effect; clear collides with a new edge
        @(posedge clk); #1; crit_src[1] = 1;
        idle(3);
        wreg(3'd2, 32'h0);
        idle(2);
        @(posedge clk); #1; crit_src[1] = 0;
        idle(2);
        @(posedge clk); #1; wr = 1; addr = 3'd2; wdata = 32'h2; crit_src[1] = 1;
        @(posedge clk); #1; wr = 0;
        idle(4);
        @(posedge clk); #1; crit_src[1] = 0;
        wreg(3'd2, 32'h2);
        idle(3);
        // R8: masked source stays off the line but shows raw
        wreg(3'd1, 32'h1fe0);
        @(posedge clk); #1; prog_src = 8'h3c;
        idle(8);
        wreg(3'd1, 32'h0);
        idle(4);
        @(posedge clk); #1; prog_src = '0;
        // R10: writes to status and unused addresses are ignored
        for (int a = 3; a < 8; a++) begin
            wreg(3'(a), 32'hffffffff);
            idle(2);
        end
        wreg(3'd2, 32'hffffffff);
        idle(3);
        // R9: random traffic, status compared every cycle
        for (int k = 0; k < 600; k++) begin
            @(posedge clk); #1;
            crit_src = crit_src ^ (4'($urandom) & 4'($urandom) & 4'($urandom));
            tmr1_src = tmr1_src ^ (($urandom % 6) == 0);
            prog_src = prog_src ^ (8'($urandom) & 8'($urandom) & 8'($urandom));
            wr = ($urandom % 3) == 0;
            addr = 3'($urandom);
            wdata = ($urandom % 2) ? 32'($urandom) : 32'($urandom) & 32'($urandom);
            if (k == 300) rst_n = 0;
            if (k == 303) rst_n = 1;
        end
        idle(6);
        done = 1;
        summary();
        $finish;
    end
endmodule